// File: doc/BRIEF.md
# Multi-Mode Timer Channel Counter

This block is the counting core of one timer channel. It keeps a 16-bit count that software can read but not write, and a capture register that holds the count at the moment of a capture event. The count moves one step on each cycle in which the count-clock enable pulse is high. The selected mode decides whether it steps down or up, which events reload or clear it, and when a completion pulse is raised.

The down-counting modes are interval, event counter and one-count. They reload from a supplied reload value and signal completion when a count edge finds the count at zero. The up-counting modes are capture and capture-with-one-count. They time the distance between a start trigger and a capture event, and raise a sticky overflow flag when the count wraps.

A channel start strobe and a stop strobe let the counting be paused and resumed. A unit enable input returns the whole channel to its idle value.

Top module: `tmr_chan_counter`

## Requirements
- R1: After reset, count_o is FFFFh, capture_o is 0000h, and done_o and ovf_o are 0.
- R2: While unit_en_i is high and mode_i is unchanged from the previous cycle, count_o changes only after a cycle in which cnt_en_i, trig_i or cap_i is high.
- R3: mode_i codes are 0 interval, 1 capture, 2 event counter, 3 one-count and 4 capture-with-one-count. Codes 5 to 7 behave as interval. On a running channel, a count edge with no other event lowers the count by one in codes 0, 2, 3 and 5 to 7, and raises it by one in codes 1 and 4.
- R4: A cycle with unit_en_i low sets count_o to FFFFh and clears done_o and ovf_o in the next cycle. The channel is then stopped until a new start strobe.
- R5: A change of mode_i presets count_o in the next cycle: to FFFFh for a down-counting mode, to 0000h for an up-counting mode. The channel stops and keeps that value until a start strobe. The one-count modes also wait for a trigger.
- R6: In interval and event modes, trig_i loads reload_i. A count edge that finds 0000h loads reload_i and raises done_o for that one cycle. done_o rises only after a cycle with cnt_en_i high.
- R7: In one-count mode, trig_i loads reload_i and starts the count. Count edges are ignored while the channel waits for a trigger. A count edge that finds 0000h raises done_o, leaves the count at 0000h and waits for the next trigger.
- R8: In capture mode, trig_i clears the count to 0000h. cap_i copies the count as it was before that cycle's edge into capture_o and clears the count, even if cnt_en_i is also high.
- R9: In capture-with-one-count mode, counting starts from 0000h at trig_i. cap_i copies the count into capture_o and leaves the count at that value plus one. The count, capture_o and further cap_i pulses are then ignored until the next trig_i.
- R10: An up-counting edge at FFFFh wraps the count to 0000h and sets ovf_o. ovf_o stays set until the next accepted capture clears it.
- R11: stop_i pauses the count at its value, taking effect in the same cycle. A later start_i resumes counting from the held value in the cycle after the strobe.
- R12: capture_o changes only after a cycle with cap_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| unit_en_i | input | 1 | Unit enable; low forces the idle state |
| cnt_en_i | input | 1 | Count-clock enable pulse, one step per high cycle |
| trig_i | input | 1 | Start trigger |
| cap_i | input | 1 | Capture event |
| start_i | input | 1 | Channel start strobe |
| stop_i | input | 1 | Channel stop strobe |
| mode_i | input | 3 | Mode select |
| reload_i | input | 16 | Reload value for the down-counting modes |
| count_o | output | 16 | Current count (read-only) |
| capture_o | output | 16 | Capture data register |
| done_o | output | 1 | One-cycle completion pulse |
| ovf_o | output | 1 | Sticky up-count overflow flag |

## Verification
The run and wait flags are not visible at the ports. A wrong value in either one shows up as count_o moving, or failing to move, on the very next count edge. A stale mode record shows up in the cycle after a mode change, because no preset appears. A wrong pre-increment choice shows up on the first capture that coincides with a count edge, as capture_o one too high. A wrong overflow flag is seen at the FFFFh to 0000h step or at the following capture.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    localparam int unsigned MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_INTERVAL     = 3'd0,
        MODE_CAPTURE      = 3'd1,
        MODE_EVENT        = 3'd2,
        MODE_ONECOUNT     = 3'd3,
        MODE_CAP_ONECOUNT = 3'd4
    } tmr_mode_e;

    typedef struct packed {
        logic up;         // count direction is upward
        logic one_count;  // stops after one count and waits for a trigger
        logic capture;    // capture clears the count (capture mode only)
    } mode_attr_t;

    function automatic mode_attr_t decode_mode(input logic [MODE_W-1:0] m);
        mode_attr_t a;
        a = '0;
        case (m)
            MODE_CAPTURE:      begin a.up = 1'b1; a.capture = 1'b1; end
            MODE_ONECOUNT:     begin a.one_count = 1'b1; end
            MODE_CAP_ONECOUNT: begin a.up = 1'b1; a.one_count = 1'b1; end
            default:           a = '0;   // interval, event and reserved codes
        endcase
        return a;
    endfunction

endpackage

// File: rtl/tmr_chan_mode_dec.sv
module tmr_chan_mode_dec
    import tmr_chan_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output mode_attr_t        attr_o
);
    always_comb begin
        attr_o = decode_mode(mode_i);
    end
endmodule

// File: rtl/tmr_chan_stepper.sv
module tmr_chan_stepper #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] cnt_i,
    output logic [WIDTH-1:0] inc_o,
    output logic [WIDTH-1:0] dec_o,
    output logic             is_zero_o,
    output logic             is_max_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        inc_o     = cnt_i + ONE;
        dec_o     = cnt_i - ONE;
        is_zero_o = (cnt_i == '0);
        is_max_o  = (cnt_i == '1);
    end
endmodule

// File: rtl/tmr_chan_counter.sv
module tmr_chan_counter
    import tmr_chan_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              unit_en_i,
    input  logic              cnt_en_i,
    input  logic              trig_i,
    input  logic              cap_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [WIDTH-1:0]  reload_i,
    output logic [WIDTH-1:0]  count_o,
    output logic [WIDTH-1:0]  capture_o,
    output logic              done_o,
    output logic              ovf_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;
    localparam logic [WIDTH-1:0] ALL_ZERO = '0;

    typedef struct packed {
        logic [WIDTH-1:0]  cnt;
        logic [WIDTH-1:0]  cap;
        logic [MODE_W-1:0] mode;
        logic              run;
        logic              waiting;
        logic              done;
        logic              ovf;
    } state_t;

    localparam state_t RESET_STATE = '{
        cnt:     ALL_ONES,
        cap:     ALL_ZERO,
        mode:    MODE_INTERVAL,
        run:     1'b0,
        waiting: 1'b1,
        done:    1'b0,
        ovf:     1'b0
    };

    state_t st_d, st_q;

    mode_attr_t       attr;
    logic [WIDTH-1:0] cnt_inc, cnt_dec;
    logic             cnt_zero, cnt_max;
    logic             mode_chg, counting;

    tmr_chan_mode_dec u_dec (
        .mode_i (mode_i),
        .attr_o (attr)
    );

    tmr_chan_stepper #(.WIDTH(WIDTH)) u_step (
        .cnt_i     (st_q.cnt),
        .inc_o     (cnt_inc),
        .dec_o     (cnt_dec),
        .is_zero_o (cnt_zero),
        .is_max_o  (cnt_max)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.mode = mode_i;
        mode_chg  = (mode_i != st_q.mode);
        counting  = st_q.run && !stop_i;

        if (!unit_en_i) begin
            st_d.cnt     = ALL_ONES;
            st_d.run     = 1'b0;
            st_d.waiting = 1'b1;
            st_d.ovf     = 1'b0;
        end else if (mode_chg) begin
            st_d.cnt     = attr.up ? ALL_ZERO : ALL_ONES;
            st_d.run     = 1'b0;
            st_d.waiting = 1'b1;
        end else begin
            if (stop_i) begin
                st_d.run = 1'b0;
            end else if (start_i) begin
                st_d.run = 1'b1;
            end

            if (counting) begin
                if (attr.up && attr.one_count) begin
                    // capture with one count
                    if (st_q.waiting) begin
                        if (trig_i) begin
                            st_d.cnt     = ALL_ZERO;
                            st_d.waiting = 1'b0;
                        end
                    end else if (cap_i) begin
                        st_d.cap     = st_q.cnt;
                        st_d.cnt     = cnt_inc;
                        st_d.waiting = 1'b1;
                        st_d.ovf     = 1'b0;
                    end else if (cnt_en_i) begin
                        st_d.cnt = cnt_inc;
                        if (cnt_max) st_d.ovf = 1'b1;
                    end
                end else if (attr.up) begin
                    // free capture
                    if (cap_i) begin
                        st_d.cap = st_q.cnt;
                        st_d.cnt = ALL_ZERO;
                        st_d.ovf = 1'b0;
                    end else if (trig_i) begin
                        st_d.cnt = ALL_ZERO;
                    end else if (cnt_en_i) begin
                        st_d.cnt = cnt_inc;
                        if (cnt_max) st_d.ovf = 1'b1;
                    end
                end else begin
                    // down-counting modes
                    if (trig_i) begin
                        st_d.cnt     = reload_i;
                        st_d.waiting = 1'b0;
                    end else if (cnt_en_i && !(attr.one_count && st_q.waiting)) begin
                        if (cnt_zero) begin
                            st_d.done = 1'b1;
                            if (attr.one_count) begin
                                st_d.waiting = 1'b1;
                            end else begin
                                st_d.cnt = reload_i;
                            end
                        end else begin
                            st_d.cnt = cnt_dec;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o   = st_q.cnt;
    assign capture_o = st_q.cap;
    assign done_o    = st_q.done;
    assign ovf_o     = st_q.ovf;

endmodule

// File: rtl/tmr_chan_counter_chk.sv
module tmr_chan_counter_chk
    import tmr_chan_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              unit_en_i,
    input logic              cnt_en_i,
    input logic              trig_i,
    input logic              cap_i,
    input logic [MODE_W-1:0] mode_i,
    input logic [WIDTH-1:0]  count_o,
    input logic [WIDTH-1:0]  capture_o,
    input logic              done_o,
    input logic              ovf_o
);
    logic seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seen_q <= 1'b0;
        else         seen_q <= 1'b1;
    end

    function automatic logic [WIDTH-1:0] preset_of(input logic [MODE_W-1:0] m);
        mode_attr_t a;
        a = decode_mode(m);
        return a.up ? '0 : '1;
    endfunction

    // R2: no count movement without an event
    p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && unit_en_i && $stable(mode_i) && !cnt_en_i && !trig_i && !cap_i)
        |=> $stable(count_o));

    // R4: unit disable forces the idle value
    p_unit_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !unit_en_i |=> (count_o == '1 && !done_o && !ovf_o));

    // R5: mode change presets the count
    p_mode_preset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seen_q && unit_en_i && !$stable(mode_i))
        |=> (count_o == preset_of($past(mode_i))));

    // R6: completion only after a count edge
    p_done_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $past(cnt_en_i));

    // R10: overflow appears together with the wrap to zero
    p_ovf_wrap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovf_o) |-> (count_o == '0));

    // R12: capture register only moves after a capture event
    p_cap_only_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cap_i |=> $stable(capture_o));

endmodule

bind tmr_chan_counter tmr_chan_counter_chk #(.WIDTH(WIDTH)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .unit_en_i (unit_en_i),
    .cnt_en_i  (cnt_en_i),
    .trig_i    (trig_i),
    .cap_i     (cap_i),
    .mode_i    (mode_i),
    .count_o   (count_o),
    .capture_o (capture_o),
    .done_o    (done_o),
    .ovf_o     (ovf_o)
);

// File: tb/tmr_chan_counter_tb_top.sv
module tmr_chan_counter_tb_top;

    localparam int unsigned W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ue = 1'b0, ce = 1'b0, tr = 1'b0, cp = 1'b0, st = 1'b0, sp = 1'b0;
    logic [2:0]    md = 3'd0;
    logic [W-1:0]  rl = '0;
    logic [W-1:0]  cnt, cap;
    logic          dn, ov;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    tmr_chan_counter #(.WIDTH(W)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .unit_en_i (ue),
        .cnt_en_i  (ce),
        .trig_i    (tr),
        .cap_i     (cp),
        .start_i   (st),
        .stop_i    (sp),
        .mode_i    (md),
        .reload_i  (rl),
        .count_o   (cnt),
        .capture_o (cap),
        .done_o    (dn),
        .ovf_o     (ov)
    );

    typedef struct packed {
        logic         ue, ce, tr, cp, st, sp;
        logic [2:0]   md;
        logic [15:0]  rl;
        logic [15:0]  ecnt;
        logic [15:0]  ecap;
        logic         edn, eov;
        logic [7:0]   req;
    } vec_t;

    localparam int NV = 46;
    localparam vec_t VECS [NV] = '{
        //ue ce tr cp st sp md  rl        cnt       cap       dn ov req
        '{1,1,0,0,0,0,3'd0,16'd3,16'hFFFF,16'h0000,0,0,8'd5},  // R5 not started
        '{1,0,0,0,1,0,3'd0,16'd3,16'hFFFF,16'h0000,0,0,8'd11}, // R11 start
        '{1,1,0,0,0,0,3'd0,16'd3,16'hFFFE,16'h0000,0,0,8'd3},  // R3 down
        '{1,0,0,0,0,0,3'd0,16'd3,16'hFFFE,16'h0000,0,0,8'd2},  // R2 idle
        '{1,0,1,0,0,0,3'd0,16'd2,16'h0002,16'h0000,0,0,8'd6},  // R6 trigger load
        '{1,1,0,0,0,0,3'd0,16'd2,16'h0001,16'h0000,0,0,8'd3},
        '{1,1,0,0,0,0,3'd0,16'd2,16'h0000,16'h0000,0,0,8'd3},
        '{1,1,0,0,0,0,3'd0,16'd2,16'h0002,16'h0000,1,0,8'd6},  // R6 reload+done
        '{1,0,0,0,0,0,3'd0,16'd2,16'h0002,16'h0000,0,0,8'd6},
        '{1,1,0,0,0,1,3'd0,16'd2,16'h0002,16'h0000,0,0,8'd11}, // R11 stop
        '{1,1,0,0,0,0,3'd0,16'd2,16'h0002,16'h0000,0,0,8'd11},
        '{1,1,0,0,1,0,3'd0,16'd2,16'h0002,16'h0000,0,0,8'd11},
        '{1,1,0,0,0,0,3'd0,16'd2,16'h0001,16'h0000,0,0,8'd11}, // R11 resume
        '{1,1,0,0,0,0,3'd1,16'd2,16'h0000,16'h0000,0,0,8'd5},  // R5 to capture
        '{1,0,0,0,1,0,3'd1,16'd2,16'h0000,16'h0000,0,0,8'd5},
        '{1,1,0,0,0,0,3'd1,16'd2,16'h0001,16'h0000,0,0,8'd3},  // R3 up
        '{1,1,0,0,0,0,3'd1,16'd2,16'h0002,16'h0000,0,0,8'd3},
        '{1,1,0,1,0,0,3'd1,16'd2,16'h0000,16'h0002,0,0,8'd8},  // R8 capture+edge
        '{1,1,0,0,0,0,3'd1,16'd2,16'h0001,16'h0002,0,0,8'd8},
        '{1,1,1,0,0,0,3'd1,16'd2,16'h0000,16'h0002,0,0,8'd8},  // R8 trigger clear
        '{1,1,0,0,0,0,3'd1,16'd2,16'h0001,16'h0002,0,0,8'd3},
        '{1,0,0,0,0,0,3'd1,16'd2,16'h0001,16'h0002,0,0,8'd12}, // R12
        '{1,0,0,0,0,0,3'd4,16'd2,16'h0000,16'h0002,0,0,8'd5},  // R5 to cap-one
        '{1,0,0,0,1,0,3'd4,16'd2,16'h0000,16'h0002,0,0,8'd5},
        '{1,1,0,0,0,0,3'd4,16'd2,16'h0000,16'h0002,0,0,8'd9},  // R9 wait trig
        '{1,0,1,0,0,0,3'd4,16'd2,16'h0000,16'h0002,0,0,8'd9},
        '{1,1,0,0,0,0,3'd4,16'd2,16'h0001,16'h0002,0,0,8'd9},
        '{1,1,0,0,0,0,3'd4,16'd2,16'h0002,16'h0002,0,0,8'd9},
        '{1,1,0,0,0,0,3'd4,16'd2,16'h0003,16'h0002,0,0,8'd9},
        '{1,1,0,1,0,0,3'd4,16'd2,16'h0004,16'h0003,0,0,8'd9},  // R9 cap, +1
        '{1,1,0,0,0,0,3'd4,16'd2,16'h0004,16'h0003,0,0,8'd9},
        '{1,0,0,1,0,0,3'd4,16'd2,16'h0004,16'h0003,0,0,8'd9},  // R9 cap ignored
        '{1,0,1,0,0,0,3'd4,16'd2,16'h0000,16'h0003,0,0,8'd9},
        '{1,0,0,0,0,0,3'd3,16'd1,16'hFFFF,16'h0003,0,0,8'd5},  // R5 to one-count
        '{1,0,0,0,1,0,3'd3,16'd1,16'hFFFF,16'h0003,0,0,8'd5},
        '{1,1,0,0,0,0,3'd3,16'd1,16'hFFFF,16'h0003,0,0,8'd7},  // R7 waits
        '{1,0,1,0,0,0,3'd3,16'd1,16'h0001,16'h0003,0,0,8'd7},
        '{1,1,0,0,0,0,3'd3,16'd1,16'h0000,16'h0003,0,0,8'd7},
        '{1,1,0,0,0,0,3'd3,16'd1,16'h0000,16'h0003,1,0,8'd7},  // R7 done
        '{1,1,0,0,0,0,3'd3,16'd1,16'h0000,16'h0003,0,0,8'd7},
        '{1,0,1,0,0,0,3'd3,16'd1,16'h0001,16'h0003,0,0,8'd7},
        '{1,0,0,0,0,0,3'd2,16'd5,16'hFFFF,16'h0003,0,0,8'd5},  // R5 to event
        '{1,0,0,0,1,0,3'd2,16'd5,16'hFFFF,16'h0003,0,0,8'd5},
        '{1,1,0,0,0,0,3'd2,16'd5,16'hFFFE,16'h0003,0,0,8'd3},
        '{0,0,0,0,0,0,3'd2,16'd5,16'hFFFF,16'h0003,0,0,8'd4},  // R4 disable
        '{1,1,0,0,0,0,3'd2,16'd5,16'hFFFF,16'h0003,0,0,8'd4}
    };

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic chk_all(input string req, input logic [W-1:0] ecnt,
                           input logic [W-1:0] ecap, input logic edn, input logic eov);
        chk(req, "count", cnt, ecnt);
        chk(req, "capture", cap, ecap);
        chk(req, "done", {15'd0, dn}, {15'd0, edn});
        chk(req, "ovf", {15'd0, ov}, {15'd0, eov});
    endtask

    task automatic step(input logic a_ue, input logic a_ce, input logic a_tr,
                        input logic a_cp, input logic a_st, input logic a_sp,
                        input logic [2:0] a_md, input logic [W-1:0] a_rl);
        ue = a_ue; ce = a_ce; tr = a_tr; cp = a_cp; st = a_st; sp = a_sp;
        md = a_md; rl = a_rl;
        @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1", 16'hFFFF, 16'h0000, 1'b0, 1'b0);   // R1 reset state

        for (int i = 0; i < NV; i++) begin
            string tag;
            step(VECS[i].ue, VECS[i].ce, VECS[i].tr, VECS[i].cp,
                 VECS[i].st, VECS[i].sp, VECS[i].md, VECS[i].rl);
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            chk_all(tag, VECS[i].ecnt, VECS[i].ecap, VECS[i].edn, VECS[i].eov);
        end

        // R10: wrap and sticky overflow in capture mode
        step(1, 0, 0, 0, 0, 0, 3'd1, '0);
        chk("R5", "capture preset", cnt, 16'h0000);
        step(1, 0, 0, 0, 1, 0, 3'd1, '0);
        for (int k = 0; k < 65535; k++) step(1, 1, 0, 0, 0, 0, 3'd1, '0);
        chk_all("R10 at max", 16'hFFFF, 16'h0003, 1'b0, 1'b0);
        step(1, 1, 0, 0, 0, 0, 3'd1, '0);
        chk_all("R10 wrap", 16'h0000, 16'h0003, 1'b0, 1'b1);
        step(1, 1, 0, 0, 0, 0, 3'd1, '0);
        chk_all("R10 sticky", 16'h0001, 16'h0003, 1'b0, 1'b1);
        step(1, 0, 0, 1, 0, 0, 3'd1, '0);
        chk_all("R10 cleared by capture", 16'h0000, 16'h0001, 1'b0, 1'b0);

        // R3: reserved code behaves as interval (counts down)
        step(1, 0, 0, 0, 0, 0, 3'd7, 16'd9);
        chk("R3", "reserved preset", cnt, 16'hFFFF);
        step(1, 0, 0, 0, 1, 0, 3'd7, 16'd9);
        step(1, 1, 0, 0, 0, 0, 3'd7, 16'd9);
        chk("R3", "reserved down", cnt, 16'hFFFE);

        // R1: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(1, 0, 0, 0, 0, 0, 3'd0, '0);
        chk_all("R1 re-reset", 16'hFFFF, 16'h0000, 1'b0, 1'b0);

        report();
        $finish;
    end

endmodule